// File: doc/BRIEF.md
# Linked-Channel PWM Timer

The block is a free-running up-counter with a programmable period and two compare channels that each drive one PWM pin. A clock divider in front of the counter slows it by a power of two. The counter can be frozen, and it can be zeroed together with the divider. Each channel has a small configuration word with four fields: an operating mode, the level forced on a compare match, a flag that makes the pin change state when the period ends, and a flag that holds the pin at full duty. Software sets the period in one register and the pulse width in each channel's compare register.

Channel 0 can also bind both channels to its own pin. In that linked mode the two compare registers act as a pair. One of them sets the pulse width now. A write to the other one queues a new width, and that width takes over only at the end of a period, so a width change never cuts a pulse short or stretches it mid-period. The pin reaches 0% and 100% duty through the way the overflow toggle and the compare action interact. No compare value is treated as a special case.

The register port is a plain synchronous write strobe with a combinational read mux. It carries no streamed data, so it has no valid/ready handshake and applies no back-pressure. A write takes effect on the clock edge at which `wr_en` is high.

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset the count reads 0, both pins are low, the control register reads 0x0001 (frozen) and the period register reads 0xFFFF. Each divider tick raises the count by 1. On the tick at which the count equals the period, an overflow event occurs and the count returns to 0, so one PWM period is period+1 ticks.
- R2: While the freeze bit (control bit 0) is 1, the count, the divider and both pin levels hold their values.
- R3: A write to the control register with bit 1 set zeroes the count and the divider at that edge. No tick occurs in that cycle. The bit is not stored and reads back as 0.
- R4: Control bits [4:2] select the divider. A value s from 0 to 6 gives one tick every 2^s clocks, and 7 behaves like 6.
- R5: In a channel configuration word, bits [3:2] are the compare action. Code 10 drives the pin low on a match and code 11 drives it high; codes 00 and 01 leave the pin alone on a match. Bit 4 (toggle flag) makes the pin invert on each overflow event. With the toggle flag set, action 10 and compare value c, the pin is high for c+1 of every period+1 ticks.
- R6: With the toggle flag clear, no overflow changes the pin. After the first match the pin rests at the compare level, which gives 0% duty for action 10 and 100% for action 11.
- R7: With bit 5 (full-duty flag) and the toggle flag both set, compare matches are ignored, and every overflow drives the pin to the inverse of action bit 2, so the duty is 100%.
- R8: When a match and an overflow occur on the same tick, the compare action wins.
- R9: Bits [1:0] of a configuration word select the mode: 00 turns the pin off (low), 01 selects independent PWM and 10 selects linked PWM. If bit 1 of channel 0's word is set, the channels are linked whatever the value of bit 0. Pin 0 is then driven with channel 0's action and flags, and pin 1 stays low.
- R10: In linked mode, channel 0's compare register is the active one first. A compare write marks that channel as next, and the next overflow event makes it active. A write to the inactive register therefore leaves the current period unchanged, and a write to the active register takes effect at once.
- R11: Clearing the link bit makes channel 0 active again and drops any pending switch.
- R12: The registers live at these addresses: 0 control, 1 period, 2/3 channel 0 config/compare, 4/5 channel 1 config/compare, 6 current count (read-only). A read returns what was written, zero-extended, with the clear bit reading 0. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | CNT_W | Read data (combinational) |
| pwm_out | output | 2 | PWM pins, channel 0 in bit 0 |

## Verification
The hardest case to reach is a queued width in linked mode, because the switch depends on when the write lands relative to the overflow. The bench reads the count back, waits until the count reads 0, writes the inactive register one cycle later and then samples the pin partway through that same period, where the old width must still apply. It then measures the next full period for the new width, and after that writes the active register to check that such a write takes effect at once. A behavioural model run on every clock also covers edges that the directed checks do not target.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG0   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP0   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG1   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMP1   = 3'd5;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd6;
  localparam int SEL_W = 3;

  // per-channel configuration word, bit 5 down to bit 0
  typedef struct packed {
    logic       full;   // hold at full duty (with toggle)
    logic       tog;    // invert on overflow
    logic [1:0] act;    // compare action: 10 drive low, 11 drive high
    logic [1:0] mode;   // 00 off, 01 independent, 1x linked (ch0)
  } ch_cfg_t;
  localparam int CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/tpp_prescaler.sv
module tpp_prescaler #(
  parameter int PS_W  = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PS_W-1:0] pre_q;
  logic [PS_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PS_W; i++) mask[i] = (int'(sel) > i);
  end

  assign tick = run && !clr && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tpp_counter.sv
module tpp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  assign ovf = tick && (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (ovf)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tpp_channel.sv
module tpp_channel
  import tpp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             ovf,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  ch_cfg_t          cfg,
  output logic             lvl
);
  logic hold_full;
  logic hit;

  assign hold_full = cfg.full && cfg.tog;
  assign hit       = tick && (cnt == cmp) && cfg.act[1] && !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lvl <= 1'b0;
    else if (!en)              lvl <= 1'b0;
    else if (hit)              lvl <= cfg.act[0];
    else if (ovf && cfg.tog)   lvl <= hold_full ? !cfg.act[0] : !lvl;
  end
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import tpp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [1:0]        pwm_out
);
  localparam int NCH = 2;

  logic             halt_q;
  logic [SEL_W-1:0] ps_q;
  logic [CNT_W-1:0] period_q;
  ch_cfg_t          cfg_q [NCH];
  logic [CNT_W-1:0] cmp_q [NCH];
  logic             clr_now, tick, ovf, linked;
  logic [CNT_W-1:0] cnt;
  logic             active_q, pend_q, pend_v_q;
  logic             cmp_wr0, cmp_wr1;
  logic [NCH-1:0]   ch_en;
  logic [CNT_W-1:0] ch_cmp [NCH];

  assign clr_now = wr_en && (wr_addr == A_CTRL) && wr_data[1];
  assign cmp_wr0 = wr_en && (wr_addr == A_CMP0);
  assign cmp_wr1 = wr_en && (wr_addr == A_CMP1);
  assign linked  = cfg_q[0].mode[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q   <= 1'b1;
      ps_q     <= '0;
      period_q <= '1;
      for (int i = 0; i < NCH; i++) begin
        cfg_q[i] <= '0;
        cmp_q[i] <= '0;
      end
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          halt_q <= wr_data[0];
          ps_q   <= wr_data[SEL_W+1:2];
        end
        A_PERIOD: period_q <= wr_data;
        A_CFG0:   cfg_q[0] <= ch_cfg_t'(wr_data[CFG_W-1:0]);
        A_CMP0:   cmp_q[0] <= wr_data;
        A_CFG1:   cfg_q[1] <= ch_cfg_t'(wr_data[CFG_W-1:0]);
        A_CMP1:   cmp_q[1] <= wr_data;
        default: ;
      endcase
    end
  end

  // linked-mode source selection: switch only at overflow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      pend_v_q <= 1'b0;
    end else if (!linked) begin
      active_q <= 1'b0;
      pend_v_q <= 1'b0;
    end else begin
      if (ovf && pend_v_q) active_q <= pend_q;
      if (cmp_wr0 || cmp_wr1) begin
        pend_q   <= cmp_wr1;
        pend_v_q <= 1'b1;
      end else if (ovf) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  tpp_prescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(!halt_q), .clr(clr_now), .sel(ps_q), .tick(tick)
  );

  tpp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr_now), .period(period_q),
    .cnt(cnt), .ovf(ovf)
  );

  always_comb begin
    ch_en[0]  = (cfg_q[0].mode != 2'b00);
    ch_en[1]  = !linked && (cfg_q[1].mode != 2'b00);
    ch_cmp[0] = (linked && active_q) ? cmp_q[1] : cmp_q[0];
    ch_cmp[1] = cmp_q[1];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tpp_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(ch_en[g]), .tick(tick), .ovf(ovf),
      .cnt(cnt), .cmp(ch_cmp[g]), .cfg(cfg_q[g]), .lvl(pwm_out[g])
    );
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:   rd_data = CNT_W'({ps_q, 1'b0, halt_q});
      A_PERIOD: rd_data = period_q;
      A_CFG0:   rd_data = CNT_W'(cfg_q[0]);
      A_CMP0:   rd_data = cmp_q[0];
      A_CFG1:   rd_data = CNT_W'(cfg_q[1]);
      A_CMP1:   rd_data = cmp_q[1];
      A_COUNT:  rd_data = cnt;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwm_pair_timer_chk.sv
module pwm_pair_timer_chk
  import tpp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             halt,
  input logic             tick,
  input logic             ovf,
  input logic             clr,
  input logic [CNT_W-1:0] cnt,
  input logic             linked,
  input logic             active,
  input ch_cfg_t          cfg0,
  input logic [1:0]       pwm_out
);
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == '0));

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf && !clr) |=> (cnt == $past(cnt) + 1'b1));

  assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> ($stable(cnt) && $stable(pwm_out)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  assert_full_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !wr_en && cfg0.mode != 2'b00 && cfg0.tog && cfg0.full)
      |=> (pwm_out[0] == !cfg0.act[0]));

  assert_pin1_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (linked && !wr_en) |=> !pwm_out[1]);

  assert_swap_at_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (linked && !ovf) |=> $stable(active));
endmodule

bind pwm_pair_timer pwm_pair_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .halt(halt_q), .tick(tick), .ovf(ovf),
  .clr(clr_now), .cnt(cnt), .linked(linked), .active(active_q), .cfg0(cfg_q[0]),
  .pwm_out(pwm_out)
);

// File: tb/pwm_pair_timer_bench.sv
`timescale 1ns/1ps
module pwm_pair_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd6;
  logic [15:0] rd_data;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_pair_timer u_pwm_pair_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  // ---------------- behavioural reference ----------------
  int m_halt, m_ps, m_period, m_cnt, m_pre, m_act, m_pend, m_pv;
  int m_cfg[2], m_cmp[2], m_lvl[2];

  function automatic int chan_next(int lvl, bit en, bit tk, bit ov, int cnt, int cmp, int cfg);
    int act = (cfg >> 2) & 3;
    bit tg  = (cfg >> 4) & 1;
    bit hf  = ((cfg >> 5) & 1) && tg;
    if (!en) return 0;
    if (tk && cnt == cmp && act >= 2 && !hf) return act & 1;
    if (ov && tg) return hf ? ((act & 1) ^ 1) : (lvl ^ 1);
    return lvl;
  endfunction

  task automatic model_reset();
    m_halt = 1; m_ps = 0; m_period = 16'hFFFF; m_cnt = 0; m_pre = 0;
    m_act = 0; m_pend = 0; m_pv = 0;
    for (int i = 0; i < 2; i++) begin m_cfg[i] = 0; m_cmp[i] = 0; m_lvl[i] = 0; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int s, msk, c0, n0, n1;
      bit clr, tk, ov, lnk, en0, en1;
      s   = (m_ps > 6) ? 6 : m_ps;
      msk = (1 << s) - 1;
      clr = wr_en && wr_addr == 0 && wr_data[1];
      tk  = !m_halt && !clr && ((m_pre & msk) == msk);
      ov  = tk && (m_cnt == m_period);
      lnk = (m_cfg[0] >> 1) & 1;
      en0 = (m_cfg[0] & 3) != 0;
      en1 = !lnk && ((m_cfg[1] & 3) != 0);
      c0  = lnk ? m_cmp[m_act] : m_cmp[0];
      n0  = chan_next(m_lvl[0], en0, tk, ov, m_cnt, c0, m_cfg[0]);
      n1  = chan_next(m_lvl[1], en1, tk, ov, m_cnt, m_cmp[1], m_cfg[1]);
      m_lvl[0] = n0; m_lvl[1] = n1;
      if (clr) m_cnt = 0; else if (ov) m_cnt = 0; else if (tk) m_cnt = (m_cnt + 1) & 16'hFFFF;
      if (clr) m_pre = 0; else if (!m_halt) m_pre = (m_pre + 1) % 64;
      if (!lnk) begin m_act = 0; m_pv = 0; end
      else begin
        if (ov && m_pv) m_act = m_pend;
        if (wr_en && (wr_addr == 3 || wr_addr == 5)) begin m_pend = (wr_addr == 5); m_pv = 1; end
        else if (ov) m_pv = 0;
      end
      if (wr_en) case (wr_addr)
        0: begin m_halt = wr_data[0]; m_ps = (wr_data >> 2) & 7; end
        1: m_period = wr_data;
        2: m_cfg[0] = wr_data & 63;
        3: m_cmp[0] = wr_data;
        4: m_cfg[1] = wr_data & 63;
        5: m_cmp[1] = wr_data;
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model, 5 ns after the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk("R5", "pin0 vs model", pwm_out[0], m_lvl[0]);
      chk("R5", "pin1 vs model", pwm_out[1], m_lvl[1]);
      if (rd_addr == 3'd6) chk("R1", "count vs model", rd_data, m_cnt);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_count(input int v);
    rd_addr = 3'd6;
    do @(negedge clk); while (rd_data != 16'(v));
  endtask

  task automatic sync0(input int per);
    wait_count(per);
    wait_count(0);
  endtask

  task automatic high_count(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      hi += pwm_out[ch];
    end
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = 3'(a);
    #1 v = rd_data;
    @(negedge clk);
    rd_addr = 3'd6;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, h0, h1, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset count", rd_data, 0);
    chk("R1", "reset pins", pwm_out, 0);
    rd(0, v); chk("R1", "reset ctrl", v, 1);
    rd(1, v); chk("R1", "reset period", v, 16'hFFFF);

    // R5 independent PWM on both pins, period 9
    wr(1, 9);
    wr(2, 'h19); wr(3, 3);
    wr(4, 'h1D); wr(5, 6);
    wr(0, 'h0);
    repeat (40) @(negedge clk);
    sync0(9);
    high_count(0, 10, h0); chk("R5", "pin0 clear-on-match high ticks", h0, 4);
    sync0(9);
    high_count(1, 10, h1); chk("R5", "pin1 set-on-match high ticks", h1, 3);
    // R1 wrap
    sync0(9);
    repeat (9) @(negedge clk);
    chk("R1", "count at period", rd_data, 9);
    @(negedge clk);
    chk("R1", "count after wrap", rd_data, 0);

    // R12 readback
    rd(1, v); chk("R12", "period readback", v, 9);
    rd(2, v); chk("R12", "cfg0 readback", v, 'h19);
    rd(5, v); chk("R12", "cmp1 readback", v, 6);
    rd(7, v); chk("R12", "unused address", v, 0);

    // R2 freeze
    wr(0, 'h1);
    c = rd_data; h0 = pwm_out;
    repeat (20) @(negedge clk);
    chk("R2", "count frozen", rd_data, c);
    chk("R2", "pins frozen", pwm_out, h0);

    // R3 clear while restarting
    wr(0, 'h2);
    chk("R3", "count cleared", rd_data, 0);
    rd(0, v); chk("R3", "clear bit reads 0", v, 0);

    // R4 divide by 4
    wr(0, 2 << 2);
    repeat (100) @(negedge clk);
    sync0(9);
    high_count(0, 40, h0); chk("R4", "div4 pin0 high clocks", h0, 16);
    // R4 code 7 acts as 64
    wr(0, 7 << 2);
    wait_count(1);
    c = 1;
    do begin @(negedge clk); c++; end while (rd_data == 16'd1);
    wait_count(3);
    c = 0;
    do begin @(negedge clk); c++; end while (rd_data == 16'd3);
    chk("R4", "code7 clocks per tick", c, 64);
    wr(0, 0);

    // R6 toggle off
    wr(2, 'h09); wr(4, 'h0D);
    repeat (25) @(negedge clk);
    sync0(9);
    high_count(0, 10, h0); chk("R6", "pin0 zero duty", h0, 0);
    sync0(9);
    high_count(1, 10, h1); chk("R6", "pin1 full via set action", h1, 10);

    // R7 full duty
    wr(2, 'h39);
    repeat (25) @(negedge clk);
    sync0(9);
    high_count(0, 10, h0); chk("R7", "full-duty flag", h0, 10);

    // R8 match on overflow tick
    wr(2, 'h19); wr(3, 9);
    repeat (25) @(negedge clk);
    sync0(9);
    high_count(0, 20, h0); chk("R8", "match wins at overflow", h0, 0);

    // R9 mode off / R5 no-action code
    wr(4, 'h1C);
    repeat (5) @(negedge clk);
    high_count(1, 10, h1); chk("R9", "mode 00 pin low", h1, 0);
    wr(4, 'h11);
    repeat (25) @(negedge clk);
    high_count(1, 20, h1); chk("R5", "action 00 pure toggle", h1, 10);

    // R9/R10 linked mode
    wr(3, 2); wr(4, 'h19); wr(5, 1);
    wr(2, 'h1A);
    repeat (25) @(negedge clk);
    sync0(9);
    high_count(0, 10, h0); chk("R10", "ch0 active first", h0, 3);
    sync0(9);
    high_count(1, 10, h1); chk("R9", "pin1 low when linked", h1, 0);
    sync0(9);
    wr(5, 7);
    wait_count(4);
    chk("R10", "staged width not applied mid-period", pwm_out[0], 0);
    sync0(9);
    high_count(0, 10, h0); chk("R10", "staged width after overflow", h0, 8);
    wr(5, 4);
    sync0(9);
    high_count(0, 10, h0); chk("R10", "active write immediate", h0, 5);
    wr(2, 'h1B);
    repeat (5) @(negedge clk);
    sync0(9);
    high_count(1, 10, h1); chk("R9", "mode 11 still linked pin1", h1, 0);
    sync0(9);
    high_count(0, 10, h0); chk("R9", "mode 11 keeps linked width", h0, 5);

    // R11 unlink
    wr(2, 'h19);
    repeat (25) @(negedge clk);
    sync0(9);
    high_count(0, 10, h0); chk("R11", "unlinked uses cmp0", h0, 3);
    sync0(9);
    high_count(1, 10, h1); chk("R11", "pin1 back independent", h1, 5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule